// File: doc/BRIEF.md
# ADC Multiplexer Scan Sequencer

This block walks an eight-input analog multiplexer through a multi-channel scan for a 12-bit sampling converter. Software programs it through a byte-wide write port. It selects the channel, the scan direction, single-ended or differential coding, and the trigger source. It can also set an optional limit on how many channels one scan converts. Each pacing tick that arrives while a scan runs produces exactly one convert strobe. The strobe carries the multiplexer code of the channel being converted.

A scan either walks down from the loaded channel to channel 0, or walks up from channel 0 to the loaded channel. When the terminal channel has been converted, the sequencer returns to the start channel and flags the end of the scan for one clock. Arming needs two writes: one that loads the channel with scan disabled, then a second that sets the scan bit. Scans start from the pacing ticks themselves, or each scan waits for an external start pulse. A tick that arrives while the converter still reports busy is dropped and sets a sticky overrun flag.

The controller has three states. In IDLE the scan is disarmed. WAIT_EXT means armed and waiting for the external start pulse. RUN means converting on ticks. The transitions are:
- arm: IDLE to RUN, or IDLE to WAIT_EXT when external start is selected.
- ext_go: WAIT_EXT to RUN on a start pulse.
- scan_end: RUN to WAIT_EXT after the terminal conversion in external mode.
- disarm: any state to IDLE when the scan bit is cleared.

Top module: `adc_scan_seq`

Register map. Each entry is an address on `wr_addr`, then the bits of `wr_data` it uses.
- 0, channel/arm: bits 2:0 hold the channel and bit 7 is the scan bit.
- 1, mode: bit 0 selects scan up, bit 1 selects differential, bit 2 selects external start.
- 2, interval staging: bits 3:0.
- 3, interval load: bit 0.
- 4, overrun clear: any write.

## Requirements
- R1: After reset, convert_start, scan_done, scan_active, overrun and mux_sel are all 0.
- R2: With scan-up clear (mode bit 0 = 0), the scan converts the loaded channel first and then steps down by one per accepted tick to channel 0. Each accepted tick gives one convert_start pulse in the following cycle, with mux_sel holding that channel's code.
- R3: With scan-up set (mode bit 0 = 1), the scan converts channel 0 first and steps up by one per accepted tick, ending at the loaded channel.
- R4: scan_done is high for one cycle together with the convert strobe of the scan's last conversion. The next accepted tick converts the start channel again.
- R5: With differential set (mode bit 1 = 1), mux_sel carries twice the logical channel number, truncated to the select width.
- R6: Channel/arm writes behave as follows.
  - A write with bit 7 = 0 loads bits 2:0 and disarms.
  - A write with bit 7 = 1 arms only if a bit-7 = 0 write has happened since reset. Its channel field is ignored.
  - While disarmed, ticks give no conversion.
- R7: A value written to the interval staging register has no effect until a write with bit 0 = 1 to the load register. A nonzero active interval N ends each scan after N conversions. Zero means no limit.
- R8: With external start set (mode bit 2 = 1), ticks are ignored until an ext_scan_start pulse. After each completed scan, ticks are ignored again until the next pulse.
- R9: A tick arriving while adc_busy is high produces no strobe and does not advance the channel. It sets overrun, which stays set until a write to the clear register.
- R10: Clearing the scan bit stops all further conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pace_tick | input | 1 | Conversion pacing pulse |
| ext_scan_start | input | 1 | External scan start pulse |
| adc_busy | input | 1 | Converter busy with the previous conversion |
| mux_sel | output | 3 | Multiplexer code of the latest conversion |
| convert_start | output | 1 | One-cycle convert strobe |
| scan_done | output | 1 | Last conversion of a scan |
| scan_active | output | 1 | Controller is in RUN |
| overrun | output | 1 | Sticky dropped-tick flag |

## Verification
The scan is run down from channel 3 and up to channel 2. Matching codes tell the two directions apart, and the extra tick after each scan separates a correct reload of the start channel from wrap-around counting. A differential run from channel 3 must show the doubled codes 6, 4, 2, 0 rather than the logical numbers. An interval of 2 applied to a scan from channel 5 shows the difference between a staged value and a loaded one. Ticks given before an external start pulse, after a completed external scan, while busy, and before a proper two-write arm all expose sequencers that convert when they should stay still.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] REG_CHAN = 3'd0;
    localparam logic [ADDR_W-1:0] REG_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] REG_IVAL = 3'd2;
    localparam logic [ADDR_W-1:0] REG_LOAD = 3'd3;
    localparam logic [ADDR_W-1:0] REG_CLR  = 3'd4;

    localparam int BIT_ARM  = 7;
    localparam int BIT_UP   = 0;
    localparam int BIT_DIFF = 1;
    localparam int BIT_EXT  = 2;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_EXT = 2'd1,
        ST_RUN      = 2'd2
    } scan_state_e;

endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
    import adc_scan_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CH_W-1:0]   load_ch,
    output logic              scan_en,
    output logic              dir_up,
    output logic              diff_mode,
    output logic              ext_mode,
    output logic [CNT_W-1:0]  ival_act,
    output logic              clr_ovr
);

    logic             loaded_q;
    logic [CNT_W-1:0] ival_stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_ch      <= '0;
            loaded_q     <= 1'b0;
            scan_en      <= 1'b0;
            dir_up       <= 1'b0;
            diff_mode    <= 1'b0;
            ext_mode     <= 1'b0;
            ival_stage_q <= '0;
            ival_act     <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_CHAN: begin
                    if (!wr_data[BIT_ARM]) begin
                        load_ch  <= wr_data[CH_W-1:0];
                        loaded_q <= 1'b1;
                        scan_en  <= 1'b0;
                    end else if (loaded_q) begin
                        scan_en  <= 1'b1;
                    end
                end
                REG_MODE: begin
                    dir_up    <= wr_data[BIT_UP];
                    diff_mode <= wr_data[BIT_DIFF];
                    ext_mode  <= wr_data[BIT_EXT];
                end
                REG_IVAL: ival_stage_q <= wr_data[CNT_W-1:0];
                REG_LOAD: begin
                    if (wr_data[0]) begin
                        ival_act <= ival_stage_q;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_ovr = wr_en && (wr_addr == REG_CLR);
    end

endmodule

// File: rtl/adc_scan_step.sv
module adc_scan_step #(
    parameter int CH_W  = 3,
    parameter int CNT_W = 4
) (
    input  logic [CH_W-1:0]  cur_ch,
    input  logic [CH_W-1:0]  load_ch,
    input  logic             dir_up,
    input  logic             diff_mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] ival,
    output logic [CH_W-1:0]  start_ch,
    output logic [CH_W-1:0]  next_ch,
    output logic             is_last,
    output logic [CH_W-1:0]  mux_code
);

    logic [CH_W-1:0]  term_ch;
    logic [CNT_W-1:0] cnt_inc;
    logic             hit_term;
    logic             hit_ival;

    always_comb begin
        start_ch = dir_up ? '0 : load_ch;
        term_ch  = dir_up ? load_ch : '0;
        next_ch  = dir_up ? CH_W'(cur_ch + 1'b1) : CH_W'(cur_ch - 1'b1);
        cnt_inc  = CNT_W'(cnt + 1'b1);
        hit_term = (cur_ch == term_ch);
        hit_ival = (ival != '0) && (cnt_inc == ival);
        is_last  = hit_term || hit_ival;
        mux_code = diff_mode ? {cur_ch[CH_W-2:0], 1'b0} : cur_ch;
    end

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
    import adc_scan_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic             ext_mode,
    input  logic             pace_tick,
    input  logic             ext_pulse,
    input  logic             adc_busy,
    input  logic             clr_ovr,
    input  logic [CH_W-1:0]  start_ch,
    input  logic [CH_W-1:0]  next_ch,
    input  logic             is_last,
    input  logic [CH_W-1:0]  mux_code,
    output logic [CH_W-1:0]  cur_ch,
    output logic [CNT_W-1:0] cnt,
    output logic [CH_W-1:0]  mux_sel,
    output logic             convert_start,
    output logic             scan_done,
    output logic             scan_active,
    output logic             overrun
);

    scan_state_e st_q, st_d;
    logic        fire;
    logic        drop;
    logic        enter_run;

    always_comb begin
        scan_active = (st_q == ST_RUN);
        fire        = scan_active && scan_en && pace_tick && !adc_busy;
        drop        = scan_active && scan_en && pace_tick && adc_busy;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (scan_en) begin
                    st_d = ext_mode ? ST_WAIT_EXT : ST_RUN;
                end
            end
            ST_WAIT_EXT: begin
                if (!scan_en) begin
                    st_d = ST_IDLE;
                end else if (ext_pulse) begin
                    st_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!scan_en) begin
                    st_d = ST_IDLE;
                end else if (fire && is_last && ext_mode) begin
                    st_d = ST_WAIT_EXT;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        enter_run = (st_q != ST_RUN) && (st_d == ST_RUN);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // outputs and channel datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch        <= '0;
            cnt           <= '0;
            mux_sel       <= '0;
            convert_start <= 1'b0;
            scan_done     <= 1'b0;
            overrun       <= 1'b0;
        end else begin
            convert_start <= fire;
            scan_done     <= fire && is_last;
            if (enter_run) begin
                cur_ch <= start_ch;
                cnt    <= '0;
            end else if (fire) begin
                mux_sel <= mux_code;
                if (is_last) begin
                    cur_ch <= start_ch;
                    cnt    <= '0;
                end else begin
                    cur_ch <= next_ch;
                    cnt    <= CNT_W'(cnt + 1'b1);
                end
            end
            if (drop) begin
                overrun <= 1'b1;
            end else if (clr_ovr) begin
                overrun <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pace_tick,
    input  logic              ext_scan_start,
    input  logic              adc_busy,
    output logic [CH_W-1:0]   mux_sel,
    output logic              convert_start,
    output logic              scan_done,
    output logic              scan_active,
    output logic              overrun
);

    logic [CH_W-1:0]  load_ch;
    logic             scan_en;
    logic             dir_up;
    logic             diff_mode;
    logic             ext_mode;
    logic [CNT_W-1:0] ival_act;
    logic             clr_ovr;
    logic [CH_W-1:0]  cur_ch;
    logic [CNT_W-1:0] cnt;
    logic [CH_W-1:0]  start_ch;
    logic [CH_W-1:0]  next_ch;
    logic             is_last;
    logic [CH_W-1:0]  mux_code;

    adc_scan_regs #(.CH_W(CH_W), .CNT_W(CNT_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load_ch   (load_ch),
        .scan_en   (scan_en),
        .dir_up    (dir_up),
        .diff_mode (diff_mode),
        .ext_mode  (ext_mode),
        .ival_act  (ival_act),
        .clr_ovr   (clr_ovr)
    );

    adc_scan_step #(.CH_W(CH_W), .CNT_W(CNT_W)) step_i (
        .cur_ch    (cur_ch),
        .load_ch   (load_ch),
        .dir_up    (dir_up),
        .diff_mode (diff_mode),
        .cnt       (cnt),
        .ival      (ival_act),
        .start_ch  (start_ch),
        .next_ch   (next_ch),
        .is_last   (is_last),
        .mux_code  (mux_code)
    );

    adc_scan_fsm #(.CH_W(CH_W), .CNT_W(CNT_W)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scan_en       (scan_en),
        .ext_mode      (ext_mode),
        .pace_tick     (pace_tick),
        .ext_pulse     (ext_scan_start),
        .adc_busy      (adc_busy),
        .clr_ovr       (clr_ovr),
        .start_ch      (start_ch),
        .next_ch       (next_ch),
        .is_last       (is_last),
        .mux_code      (mux_code),
        .cur_ch        (cur_ch),
        .cnt           (cnt),
        .mux_sel       (mux_sel),
        .convert_start (convert_start),
        .scan_done     (scan_done),
        .scan_active   (scan_active),
        .overrun       (overrun)
    );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
    import adc_scan_pkg::*;
#(
    parameter int CH_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              pace_tick,
    input logic              adc_busy,
    input logic              diff_mode,
    input logic [CH_W-1:0]   mux_sel,
    input logic              convert_start,
    input logic              scan_done,
    input logic              scan_active,
    input logic              overrun
);

    assert_conv_from_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        convert_start |-> $past(pace_tick && !adc_busy));

    assert_done_with_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> convert_start);

    assert_diff_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (convert_start && $past(diff_mode)) |-> !mux_sel[0]);

    assert_conv_only_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
        convert_start |-> $past(scan_active));

    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(wr_en && wr_addr == REG_CLR)) |=> overrun);

    assert_ovr_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(pace_tick && adc_busy));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .pace_tick     (pace_tick),
    .adc_busy      (adc_busy),
    .diff_mode     (diff_mode),
    .mux_sel       (mux_sel),
    .convert_start (convert_start),
    .scan_done     (scan_done),
    .scan_active   (scan_active),
    .overrun       (overrun)
);

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pace_tick = 1'b0;
    logic       ext_scan_start = 1'b0;
    logic       adc_busy = 1'b0;
    logic [2:0] mux_sel;
    logic       convert_start;
    logic       scan_done;
    logic       scan_active;
    logic       overrun;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc_scan_seq dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .pace_tick      (pace_tick),
        .ext_scan_start (ext_scan_start),
        .adc_busy       (adc_busy),
        .mux_sel        (mux_sel),
        .convert_start  (convert_start),
        .scan_done      (scan_done),
        .scan_active    (scan_active),
        .overrun        (overrun)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one tick; checks the strobe that follows it
    task automatic tick(input string tag, input bit exp_conv, input int exp_mux, input bit exp_done);
        @(negedge clk);
        pace_tick = 1'b1;
        @(negedge clk);
        pace_tick = 1'b0;
        check({tag, " convert_start"}, int'(convert_start), int'(exp_conv));
        check({tag, " scan_done"}, int'(scan_done), int'(exp_done));
        if (exp_conv) check({tag, " mux_sel"}, int'(mux_sel), exp_mux);
    endtask

    task automatic arm(input logic [7:0] mode, input logic [2:0] ch);
        wr(3'd1, mode);
        wr(3'd0, {5'b0, ch});
        wr(3'd0, 8'h80);
        idle(1);
    endtask

    task automatic disarm();
        wr(3'd0, 8'h00);
        idle(1);
    endtask

    task automatic t_reset();
        check("R1 convert_start", int'(convert_start), 0);
        check("R1 scan_done", int'(scan_done), 0);
        check("R1 scan_active", int'(scan_active), 0);
        check("R1 overrun", int'(overrun), 0);
        check("R1 mux_sel", int'(mux_sel), 0);
    endtask

    task automatic t_down();
        arm(8'h00, 3'd3);
        for (int i = 0; i < 4; i++) tick("R2 down", 1'b1, 3 - i, i == 3);
        tick("R4 reload down", 1'b1, 3, 1'b0);
        disarm();
        tick("R10 disabled", 1'b0, 0, 1'b0);
    endtask

    task automatic t_up();
        arm(8'h01, 3'd2);
        for (int i = 0; i < 3; i++) tick("R3 up", 1'b1, i, i == 2);
        tick("R4 reload up", 1'b1, 0, 1'b0);
        disarm();
    endtask

    task automatic t_diff();
        arm(8'h02, 3'd3);
        for (int i = 0; i < 4; i++) tick("R5 diff", 1'b1, 2 * (3 - i), i == 3);
        disarm();
        wr(3'd1, 8'h00);
    endtask

    task automatic t_arm_rule();
        do_reset();
        wr(3'd0, 8'h85);
        idle(2);
        check("R6 no arm without load", int'(scan_active), 0);
        tick("R6 unarmed tick", 1'b0, 0, 1'b0);
        wr(3'd0, 8'h05);
        wr(3'd0, 8'h81);
        idle(1);
        tick("R6 arm field ignored", 1'b1, 5, 1'b0);
        disarm();
    endtask

    task automatic t_interval();
        wr(3'd2, 8'h02);
        arm(8'h00, 3'd5);
        for (int i = 0; i < 6; i++) tick("R7 staged only", 1'b1, 5 - i, i == 5);
        disarm();
        wr(3'd3, 8'h01);
        arm(8'h00, 3'd5);
        for (int k = 0; k < 2; k++) begin
            tick("R7 limited", 1'b1, 5, 1'b0);
            tick("R7 limited end", 1'b1, 4, 1'b1);
        end
        disarm();
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h01);
    endtask

    task automatic t_ext();
        arm(8'h04, 3'd1);
        idle(1);
        tick("R8 before pulse", 1'b0, 0, 1'b0);
        @(negedge clk); ext_scan_start = 1'b1;
        @(negedge clk); ext_scan_start = 1'b0;
        tick("R8 run", 1'b1, 1, 1'b0);
        tick("R8 run end", 1'b1, 0, 1'b1);
        tick("R8 after scan", 1'b0, 0, 1'b0);
        @(negedge clk); ext_scan_start = 1'b1;
        @(negedge clk); ext_scan_start = 1'b0;
        tick("R8 second scan", 1'b1, 1, 1'b0);
        disarm();
        wr(3'd1, 8'h00);
    endtask

    task automatic t_overrun();
        arm(8'h00, 3'd2);
        adc_busy = 1'b1;
        tick("R9 busy drop", 1'b0, 0, 1'b0);
        adc_busy = 1'b0;
        check("R9 overrun set", int'(overrun), 1);
        idle(2);
        check("R9 overrun held", int'(overrun), 1);
        tick("R9 channel held", 1'b1, 2, 1'b0);
        wr(3'd4, 8'h00);
        check("R9 overrun cleared", int'(overrun), 0);
        disarm();
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        t_reset();
        t_down();
        t_up();
        t_diff();
        t_arm_rule();
        t_interval();
        t_ext();
        t_overrun();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule